// File: doc/BRIEF.md
# 8x8 Fixed-Point Forward DCT

This block computes a two-dimensional forward discrete cosine transform of an 8x8 tile of signed 16-bit samples. The tile arrives as eight row beats on a valid/ready input stream. Each sample is scaled up by four. The block then applies an 8-point 1-D transform twice. Each pass reads one column of a tile buffer and writes the result as one row of the next buffer, so every pass is followed by a transpose. Each final coefficient is halved toward zero. The 64 coefficients leave as eight row beats on a valid/ready output stream.

The 8-point transform splits into an even half and an odd half. The even half is a 4-point core on the butterfly sums. The odd half has three steps: a rotation by the 45-degree constant, a second butterfly, and a rotation with four constants. All constants are 14-bit fixed point. Every product is rounded to nearest and narrowed to 16 bits. Butterfly sums wrap at 16 bits, so the numeric behaviour can be matched bit for bit by a software model. The block holds a single tile at a time: it accepts a new tile only after the previous tile has been fully read out.

Top module: `fdct8x8`

## Requirements
- R1: After reset, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: Sample c of an input row sits in bits [16c+15:16c] of `in_row_i`. Before the first pass, each sample is shifted left by 2, and the result wraps to 16 bits.
- R3: A tile takes exactly eight accepted input beats. Once the eighth beat is accepted, `in_ready_o` stays 0 until the tile has been read out, and `in_ready_o` is never 1 while `out_valid_o` is 1.
- R4: `out_valid_o` rises on the 16th rising edge after the edge that accepts the eighth input row.
- R5: Output beat k carries coefficient (k, m) in bits [16m+15:16m]. While `out_valid_o` is 1 and `out_ready_i` is 0, the beat and its data hold steady.
- R6: Butterfly sums and differences wrap at 16 bits. Each product or sum of two products is formed at 32 bits, rounded by adding 2^13, arithmetic-shifted right by 14, and keeps its low 16 bits.
- R7: With inputs v, the butterflies are s_k = v_k + v_(7-k) and s_(7-k) = v_k - v_(7-k) for k < 4. The even half uses x0 = s0+s3, x1 = s1+s2, x2 = s1-s2 and x3 = s0-s3. Its outputs are o0 = (x0+x1)·11585, o4 = (x0-x1)·11585, o2 = x2·6270 + x3·15137, and o6 = x3·6270 - x2·15137.
- R8: The odd half forms a = round((s6-s5)·11585) and b = round((s6+s5)·11585). It then forms y0 = s4+a, y1 = s4-a, y2 = s7-b and y3 = s7+b. Its outputs are o1 = y3·16069 + y0·3196, o5 = y1·13623 + y2·9102, o3 = y2·13623 - y1·9102, and o7 = y3·3196 - y0·16069.
- R9: The first pass transforms each column of the scaled tile, down the row index. Result k of column c becomes entry (c, k). The second pass transforms each column k of that intermediate. Result m becomes output coefficient (k, m).
- R10: Each second-pass result n is output as (n - sgn) >> 1, where sgn is -1 for negative n and 0 otherwise. The shift is arithmetic, so odd negative values round toward zero.
- R11: On the edge that completes the eighth output handshake, `out_valid_o` drops and `in_ready_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input row valid |
| in_ready_o | output | 1 | Block can accept an input row |
| in_row_i | input | 128 | Eight signed 16-bit samples, column 0 in the LSBs |
| out_valid_o | output | 1 | Output row valid |
| out_ready_i | input | 1 | Consumer accepts the output row |
| out_row_o | output | 128 | Eight signed 16-bit coefficients, column 0 in the LSBs |

## Verification
The hardest conditions to reach from the ports are the 16-bit wraps inside the butterflies and an odd negative second-pass value at the final halving. Smooth image data hits neither. The bench therefore sends full-range random tiles and compares all 64 coefficients against an independent integer model that wraps at the same points. It also sends a constant tile of 8192, whose scaled samples wrap to -32768 and whose first butterfly sums cancel to zero. Backpressure is applied in the middle of a drain to show that the beat holds.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int N   = 8;
  localparam int H   = N / 2;
  localparam int DW  = 16;
  localparam int MW  = 2 * DW;
  localparam int CB  = 14;
  localparam int PS  = 2;
  localparam int IW  = $clog2(N);
  localparam int RND = 1 << (CB - 1);

  typedef logic signed [DW-1:0] smp_t;
  typedef logic signed [MW-1:0] acc_t;

  localparam acc_t C4  = 16069;
  localparam acc_t C8  = 15137;
  localparam acc_t C12 = 13623;
  localparam acc_t C16 = 11585;
  localparam acc_t C20 = 9102;
  localparam acc_t C24 = 6270;
  localparam acc_t C28 = 3196;

  typedef enum logic [1:0] {PH_LOAD, PH_PASS1, PH_PASS2, PH_DRAIN} phase_e;

  // round to nearest, shift by CB, keep DW bits
  function automatic smp_t rshr(acc_t p);
    logic [MW:0] t;
    t = {p[MW-1], p} + (MW+1)'(RND);
    return smp_t'(t[CB+DW-1:CB]);
  endfunction

  function automatic smp_t prescale(smp_t v);
    return v <<< PS;
  endfunction

  // halve toward zero: (n - sign) >> 1
  function automatic smp_t halve(smp_t n);
    logic [DW:0] w;
    w = {n[DW-1], n} - {(DW+1){n[DW-1]}};
    return smp_t'(w[DW:1]);
  endfunction
endpackage

// File: rtl/fdct_even.sv
module fdct_even
  import fdct_pkg::*;
(
  input  smp_t s_i [H],
  output smp_t e_o [H]
);
  smp_t x0, x1, x2, x3;

  always_comb begin
    x0 = s_i[0] + s_i[3];
    x1 = s_i[1] + s_i[2];
    x2 = s_i[1] - s_i[2];
    x3 = s_i[0] - s_i[3];
    e_o[0] = rshr((acc_t'(x0) + acc_t'(x1)) * C16);
    e_o[1] = rshr(acc_t'(x2) * C24 + acc_t'(x3) * C8);
    e_o[2] = rshr((acc_t'(x0) - acc_t'(x1)) * C16);
    e_o[3] = rshr(acc_t'(x3) * C24 - acc_t'(x2) * C8);
  end
endmodule

// File: rtl/fdct_odd.sv
module fdct_odd
  import fdct_pkg::*;
(
  input  smp_t d_i [H],
  output smp_t o_o [H]
);
  smp_t dif, sum, a, b, y0, y1, y2, y3;

  always_comb begin
    dif = d_i[2] - d_i[1];
    sum = d_i[2] + d_i[1];
    a   = rshr(acc_t'(dif) * C16);
    b   = rshr(acc_t'(sum) * C16);
    y0  = d_i[0] + a;
    y1  = d_i[0] - a;
    y2  = d_i[3] - b;
    y3  = d_i[3] + b;
    o_o[0] = rshr(acc_t'(y3) * C4  + acc_t'(y0) * C28);
    o_o[1] = rshr(acc_t'(y2) * C12 - acc_t'(y1) * C20);
    o_o[2] = rshr(acc_t'(y1) * C12 + acc_t'(y2) * C20);
    o_o[3] = rshr(acc_t'(y3) * C28 - acc_t'(y0) * C4);
  end
endmodule

// File: rtl/fdct_ctrl.sv
module fdct_ctrl
  import fdct_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          out_ready_i,
  output phase_e        phase_o,
  output logic [IW-1:0] idx_o,
  output logic          in_ready_o,
  output logic          out_valid_o
);
  logic   adv, last;
  phase_e nxt;

  assign in_ready_o  = (phase_o == PH_LOAD);
  assign out_valid_o = (phase_o == PH_DRAIN);
  assign last        = (idx_o == IW'(N-1));

  always_comb begin
    case (phase_o)
      PH_LOAD:  begin adv = in_valid_i;  nxt = PH_PASS1; end
      PH_PASS1: begin adv = 1'b1;        nxt = PH_PASS2; end
      PH_PASS2: begin adv = 1'b1;        nxt = PH_DRAIN; end
      default:  begin adv = out_ready_i; nxt = PH_LOAD;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_LOAD;
      idx_o   <= '0;
    end else if (adv) begin
      idx_o <= idx_o + IW'(1);
      if (last) phase_o <= nxt;
    end
  end
endmodule

// File: rtl/fdct8x8.sv
module fdct8x8
  import fdct_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [N*DW-1:0] in_row_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [N*DW-1:0] out_row_o
);
  phase_e        phase;
  logic [IW-1:0] idx;

  smp_t buf_a [N][N];
  smp_t buf_b [N][N];
  smp_t col   [N];
  smp_t stp   [N];
  smp_t ev    [H];
  smp_t od    [H];
  smp_t res   [N];

  fdct_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .phase_o     (phase),
    .idx_o       (idx),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o)
  );

  // column idx of the source buffer for the current pass
  always_comb begin
    for (int r = 0; r < N; r++)
      col[r] = (phase == PH_PASS1) ? buf_a[r][idx] : buf_b[r][idx];
  end

  for (genvar k = 0; k < H; k++) begin : g_bfly
    assign stp[k]     = col[k] + col[N-1-k];
    assign stp[N-1-k] = col[k] - col[N-1-k];
  end

  fdct_even u_even (.s_i(stp[0:H-1]), .e_o(ev));
  fdct_odd  u_odd  (.d_i(stp[H:N-1]), .o_o(od));

  for (genvar j = 0; j < H; j++) begin : g_mix
    assign res[2*j]   = ev[j];
    assign res[2*j+1] = od[j];
  end

  // each pass reads column idx and writes row idx: transpose per pass
  always_ff @(posedge clk_i) begin
    case (phase)
      PH_LOAD:
        if (in_valid_i)
          for (int c = 0; c < N; c++)
            buf_a[idx][c] <= prescale(smp_t'(in_row_i[c*DW +: DW]));
      PH_PASS1:
        for (int k = 0; k < N; k++) buf_b[idx][k] <= res[k];
      PH_PASS2:
        for (int k = 0; k < N; k++) buf_a[idx][k] <= halve(res[k]);
      default: ;
    endcase
  end

  always_comb begin
    for (int m = 0; m < N; m++) out_row_o[m*DW +: DW] = buf_a[idx][m];
  end
endmodule

// File: rtl/fdct8x8_chk.sv
module fdct8x8_chk
  import fdct_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [N*DW-1:0] out_row_o
);
  localparam int LAT = 2 * N;
  localparam int LW  = $clog2(LAT + 1);

  logic [IW-1:0] in_cnt, out_cnt;
  logic [LW-1:0] lat_cnt;
  logic          busy;
  logic          in_hs, out_hs;

  assign in_hs  = in_valid_i && in_ready_o;
  assign out_hs = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt  <= '0;
      out_cnt <= '0;
      lat_cnt <= '0;
      busy    <= 1'b0;
    end else begin
      if (in_hs)  in_cnt  <= in_cnt + IW'(1);
      if (out_hs) out_cnt <= out_cnt + IW'(1);
      if (in_hs && in_cnt == IW'(N-1)) begin
        busy    <= 1'b1;
        lat_cnt <= '0;
      end else if (busy) begin
        if (lat_cnt == LW'(LAT)) busy <= 1'b0;
        else lat_cnt <= lat_cnt + LW'(1);
      end
    end
  end

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  p_in_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hs && in_cnt == IW'(N-1) |=> !in_ready_o);

  p_latency_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && lat_cnt < LW'(LAT) |-> !out_valid_o);

  p_latency_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && lat_cnt == LW'(LAT) |-> out_valid_o);

  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_row_o));

  p_reopen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hs && out_cnt == IW'(N-1) |=> in_ready_o && !out_valid_o);
endmodule

bind fdct8x8 fdct8x8_chk u_chk (.*);

// File: tb/fdct8x8_tb.sv
module fdct8x8_tb;
  import fdct_pkg::*;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            out_ready = 1'b0;
  logic [N*DW-1:0] in_row = '0;
  logic [N*DW-1:0] out_row;
  logic            in_ready, out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fdct8x8 u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_row_i    (in_row),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_row_o   (out_row)
  );

  // constant-fill tiles and the hand-derived DC coefficient (all others 0)
  localparam int NT = 5;
  localparam int FILL   [NT] = '{0, 1, -1, 100, 8192};
  localparam int EXP_DC [NT] = '{0, 65, -65, 6400, 0};

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic shortint rs(input longint p);
    return shortint'((p + 8192) >>> 14);
  endfunction

  function automatic shortint hv(input shortint n);
    int w;
    w = n;
    if (n < 0) w = w + 1;
    return shortint'(w >>> 1);
  endfunction

  task automatic dct1(input shortint v[8], output shortint o[8]);
    shortint s[8];
    shortint x0, x1, x2, x3, a, b, y0, y1, y2, y3;
    for (int k = 0; k < 4; k++) begin
      s[k]   = v[k] + v[7-k];
      s[7-k] = v[k] - v[7-k];
    end
    x0 = s[0] + s[3]; x1 = s[1] + s[2];
    x2 = s[1] - s[2]; x3 = s[0] - s[3];
    o[0] = rs((longint'(x0) + x1) * 11585);
    o[4] = rs((longint'(x0) - x1) * 11585);
    o[2] = rs(longint'(x2) * 6270 + longint'(x3) * 15137);
    o[6] = rs(longint'(x3) * 6270 - longint'(x2) * 15137);
    x0 = s[6] - s[5];
    x1 = s[6] + s[5];
    a = rs(longint'(x0) * 11585);
    b = rs(longint'(x1) * 11585);
    y0 = s[4] + a; y1 = s[4] - a; y2 = s[7] - b; y3 = s[7] + b;
    o[1] = rs(longint'(y3) * 16069 + longint'(y0) * 3196);
    o[5] = rs(longint'(y1) * 13623 + longint'(y2) * 9102);
    o[3] = rs(longint'(y2) * 13623 - longint'(y1) * 9102);
    o[7] = rs(longint'(y3) * 3196 - longint'(y0) * 16069);
  endtask

  task automatic ref_blk(input shortint x[8][8], output shortint q[8][8]);
    shortint t[8][8];
    shortint cv[8];
    shortint rv[8];
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) cv[r] = shortint'(x[r][c] * 4);
      dct1(cv, rv);
      for (int k = 0; k < 8; k++) t[c][k] = rv[k];
    end
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 8; c++) cv[c] = t[c][k];
      dct1(cv, rv);
      for (int m = 0; m < 8; m++) q[k][m] = hv(rv[m]);
    end
  endtask

  function automatic logic [N*DW-1:0] pack(input shortint v[8]);
    logic [N*DW-1:0] p;
    for (int c = 0; c < 8; c++) p[c*DW +: DW] = v[c];
    return p;
  endfunction

  task automatic run_block(input shortint blk[8][8], input bit stall,
                           output shortint got[8][8]);
    int lat;
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      if (r == 0) chk(in_ready === 1'b1, "R3", "in_ready before tile", in_ready, 1);
      in_valid = 1'b1;
      in_row   = pack(blk[r]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready === 1'b0, "R3", "in_ready after eighth beat", in_ready, 0);
    lat = 0;
    while (!out_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 16, "R4", "edges to first output beat", lat, 16);
    out_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (stall && k == 2) begin
        logic [N*DW-1:0] held;
        held = out_row;
        out_ready = 1'b0;
        for (int w = 0; w < 3; w++) begin
          @(negedge clk);
          chk(out_valid === 1'b1 && out_row === held, "R5", "beat held under stall",
              out_valid, 1);
        end
        out_ready = 1'b1;
      end
      for (int m = 0; m < 8; m++) got[k][m] = shortint'(out_row[m*DW +: DW]);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R11", "in_ready after drain",
        in_ready, 1);
  endtask

  task automatic cmp_blk(input shortint got[8][8], input shortint exp[8][8],
                         input string tag);
    int bad;
    int fk;
    int fm;
    bad = 0; fk = 0; fm = 0;
    for (int k = 0; k < 8; k++)
      for (int m = 0; m < 8; m++)
        if (got[k][m] != exp[k][m]) begin
          if (bad == 0) begin fk = k; fm = m; end
          bad++;
        end
    chk(bad == 0, tag, $sformatf("coef(%0d,%0d)", fk, fm), got[fk][fm], exp[fk][fm]);
  endtask

  initial begin
    shortint blk[8][8];
    shortint got[8][8];
    shortint exp[8][8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1", "idle after reset", in_ready, 1);

    for (int t = 0; t < NT; t++) begin
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) begin
          blk[r][c] = shortint'(FILL[t]);
          exp[r][c] = 0;
        end
      exp[0][0] = shortint'(EXP_DC[t]);
      run_block(blk, 1'b0, got);
      cmp_blk(got, exp, "R2 R6 R7 constant tile");
    end

    // single impulse off the diagonal: transform order and row/column mapping
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) blk[r][c] = 0;
    blk[1][6] = 700;
    ref_blk(blk, exp);
    run_block(blk, 1'b0, got);
    cmp_blk(got, exp, "R9 impulse");

    // vertical ramp: odd-half rotations
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) blk[r][c] = shortint'((r * 37) - 150 + c);
    ref_blk(blk, exp);
    run_block(blk, 1'b1, got);
    cmp_blk(got, exp, "R8 ramp");

    // full-range random tiles: wraps and negative odd halving
    for (int n = 0; n < 6; n++) begin
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          blk[r][c] = (n < 3) ? shortint'($urandom) : shortint'($urandom_range(0, 511)) - 256;
      ref_blk(blk, exp);
      run_block(blk, n == 4, got);
      cmp_blk(got, exp, "R6 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4: actual %0d expected %0d", 50000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule